// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital mode controller of a LIN physical-layer interface. It chooses among four operating modes (normal slope, low slope, standby and sleep) and decodes from the mode the enables for the voltage regulator, the bus transmitter, the slope selection, the bus termination and the inhibit output. The mode changes on synchronized edges of the enable pin, qualified by the level of the transmit-data pin (on a rising edge) or the standby pin (on a falling edge) seen in the same cycle as that edge.

The enable, standby and transmit-data pins enter through two-flop synchronizers. The wake-event strobe, the undervoltage flag, the reset-active flag and the thermal-shutdown flag come from on-chip blocks in the same clock domain and are used without synchronization. The inhibit drive latches the standby pin level sampled at the moment a normal mode is entered. The thermal flag only masks the regulator and transmitter enables and leaves the mode unchanged.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While rst_ni is low the mode is standby. The mode code on mode_o is 00 sleep, 01 standby, 10 normal slope, 11 low slope. In standby, vreg_en_o=1 and tx_en_o, slope_low_o, term_res_o and inh_hi_o are all 0.
- R2: In standby, a rising edge on en_i with txd_i high enters normal slope. mode_o changes on the third rising clock edge after en_i changes, and the transmitter is enabled whatever the level of txd_i.
- R3: In standby, a rising edge on en_i with txd_i low enters low slope with slope_low_o=1. tx_en_o stays 0 until txd_i has been seen high after the entry.
- R4: In either normal mode, a falling edge on en_i with stb_i high goes to standby and with stb_i low goes to sleep. A falling edge on en_i in standby has no effect.
- R5: inh_hi_o is 1 in a normal mode only if stb_i was high at the edge that entered that mode. Later changes of stb_i do not alter it, and it is 0 in standby and sleep.
- R6: vreg_en_o is 1 in every mode except sleep. term_res_o (1 = resistor termination, 0 = pull-up current source) is 1 only in the two normal modes.
- R7: A wake strobe in sleep moves the mode to standby on the next clock edge. An edge on en_i in sleep has no effect.
- R8: Undervoltage in standby or in a normal mode forces standby on the next clock edge and holds it while the flag is set. Undervoltage in sleep has no effect.
- R9: While rst_act_i is high, edges on en_i and the levels of stb_i and txd_i cause no mode change. An en_i edge that occurs during that time is not acted on after rst_act_i falls.
- R10: While tsd_i is high, vreg_en_o and tx_en_o are 0 and the mode is unchanged. The outputs recover when tsd_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable pin, asynchronous |
| stb_i | input | 1 | Standby pin, asynchronous |
| txd_i | input | 1 | Transmit-data pin, asynchronous, low = dominant |
| wake_i | input | 1 | Wake-event strobe from the wake detector |
| uv_i | input | 1 | Regulator undervoltage flag |
| rst_act_i | input | 1 | Reset output of the supervisor is active |
| tsd_i | input | 1 | Thermal shutdown flag |
| mode_o | output | 2 | Mode code |
| vreg_en_o | output | 1 | Regulator enable |
| tx_en_o | output | 1 | Transmitter enable |
| slope_low_o | output | 1 | Reduced slew-rate select |
| term_res_o | output | 1 | 1 = resistor termination, 0 = current source |
| inh_hi_o | output | 1 | 1 = drive INH high, 0 = float |

## Verification
A pin change reaches the mode register on the third rising clock edge: two synchronizer stages, then the mode flop, which acts when the edge detector compares against the previous sample. The low-slope transmitter arming takes the same three edges after txd_i rises. The wake, undervoltage and reset-active inputs act on the next edge, and the thermal flag and the mode-decoded outputs follow combinationally. Each table row is held for five clock cycles and sampled on the falling edge that follows, so every path has settled. One directed test samples after the second and after the third edge to pin the pin-to-mode latency exactly, and another checks the asynchronous reset while rst_ni is still low.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_STBY  = 2'b01,
    MODE_NORM  = 2'b10,
    MODE_LOWS  = 2'b11
  } mode_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned PIN_W       = 3;
  localparam int unsigned PIN_EN      = 2;
  localparam int unsigned PIN_STB     = 1;
  localparam int unsigned PIN_TXD     = 0;
endpackage

// File: rtl/lin_pin_sync.sv
module lin_pin_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_s_i,
  input  logic  stb_s_i,
  input  logic  txd_s_i,
  input  logic  wake_i,
  input  logic  uv_i,
  input  logic  rst_act_i,
  output mode_e mode_o,
  output logic  tx_arm_o,
  output logic  inh_lat_o
);
  mode_e mode_q, mode_d;
  logic  en_q, en_rise, en_fall;
  logic  arm_q, inh_q;
  logic  enter_norm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else en_q <= en_s_i;
  end

  // edges seen during reset-active are consumed, never replayed
  assign en_rise = en_s_i & ~en_q & ~rst_act_i;
  assign en_fall = ~en_s_i & en_q & ~rst_act_i;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_SLEEP: if (wake_i) mode_d = MODE_STBY;
      MODE_STBY:  if (!uv_i && en_rise) mode_d = txd_s_i ? MODE_NORM : MODE_LOWS;
      default: begin
        if (uv_i) mode_d = MODE_STBY;
        else if (en_fall) mode_d = stb_s_i ? MODE_STBY : MODE_SLEEP;
      end
    endcase
  end

  assign enter_norm = (mode_q == MODE_STBY) &&
                      (mode_d == MODE_NORM || mode_d == MODE_LOWS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STBY;
      arm_q  <= 1'b0;
      inh_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (enter_norm) arm_q <= 1'b0;
      else if (mode_q == MODE_LOWS && txd_s_i && !rst_act_i) arm_q <= 1'b1;
      if (enter_norm) inh_q <= stb_s_i;
      else if (mode_d == MODE_STBY || mode_d == MODE_SLEEP) inh_q <= 1'b0;
    end
  end

  assign mode_o    = mode_q;
  assign tx_arm_o  = arm_q;
  assign inh_lat_o = inh_q;

  assert_pins_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_act_i && !uv_i && !(mode_q == MODE_SLEEP && wake_i)) |=> $stable(mode_q));

  assert_uv_forces_stby_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_i && mode_q != MODE_SLEEP) |=> (mode_q == MODE_STBY));

  assert_wake_leaves_sleep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && wake_i) |=> (mode_q == MODE_STBY));

  assert_stby_never_sleeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STBY) |=> (mode_q != MODE_SLEEP));

  assert_norm_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_NORM && !uv_i && !en_fall) |=> (mode_q == MODE_NORM));
endmodule

// File: rtl/lin_drive_dec.sv
module lin_drive_dec
  import lin_mode_pkg::*;
(
  input  mode_e mode_i,
  input  logic  tx_arm_i,
  input  logic  inh_lat_i,
  input  logic  tsd_i,
  output logic  vreg_en_o,
  output logic  tx_en_o,
  output logic  slope_low_o,
  output logic  term_res_o,
  output logic  inh_hi_o
);
  logic active, tx_mode;

  assign active  = (mode_i == MODE_NORM) || (mode_i == MODE_LOWS);
  assign tx_mode = (mode_i == MODE_NORM) || (mode_i == MODE_LOWS && tx_arm_i);

  assign vreg_en_o   = (mode_i != MODE_SLEEP) && !tsd_i;
  assign tx_en_o     = tx_mode && !tsd_i;
  assign slope_low_o = (mode_i == MODE_LOWS);
  assign term_res_o  = active;
  assign inh_hi_o    = active && inh_lat_i;

  always_comb begin
    assert_tsd_kills_tx_R10: assert (!(tsd_i && (tx_en_o || vreg_en_o)));
    assert_stby_sleep_quiet_R6: assert (active || !(tx_en_o || term_res_o || inh_hi_o));
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       stb_i,
  input  logic       txd_i,
  input  logic       wake_i,
  input  logic       uv_i,
  input  logic       rst_act_i,
  input  logic       tsd_i,
  output logic [1:0] mode_o,
  output logic       vreg_en_o,
  output logic       tx_en_o,
  output logic       slope_low_o,
  output logic       term_res_o,
  output logic       inh_hi_o
);
  logic [PIN_W-1:0] pins_s;
  mode_e mode;
  logic  tx_arm, inh_lat;

  lin_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_i, stb_i, txd_i}),
    .q_o   (pins_s)
  );

  lin_mode_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_s_i   (pins_s[PIN_EN]),
    .stb_s_i  (pins_s[PIN_STB]),
    .txd_s_i  (pins_s[PIN_TXD]),
    .wake_i   (wake_i),
    .uv_i     (uv_i),
    .rst_act_i(rst_act_i),
    .mode_o   (mode),
    .tx_arm_o (tx_arm),
    .inh_lat_o(inh_lat)
  );

  lin_drive_dec u_dec (
    .mode_i     (mode),
    .tx_arm_i   (tx_arm),
    .inh_lat_i  (inh_lat),
    .tsd_i      (tsd_i),
    .vreg_en_o  (vreg_en_o),
    .tx_en_o    (tx_en_o),
    .slope_low_o(slope_low_o),
    .term_res_o (term_res_o),
    .inh_hi_o   (inh_hi_o)
  );

  assign mode_o = mode;
endmodule

// File: tb/tb_lin_mode_ctrl.sv
module tb_lin_mode_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HOLD       = 5;
  localparam int  WDOG       = 20000;
  localparam int  NVEC       = 29;

  // {en,stb,txd,wake,uv,rst_act,tsd} _ mode _ {vreg,tx,slope_low,term_res,inh}
  localparam logic [13:0] VEC [NVEC] = '{
    14'b0110000_01_10000, // 0  R1 idle standby
    14'b1110000_10_11011, // 1  R2 R5 normal, inh latched high
    14'b1100000_10_11011, // 2  R2 txd low keeps tx enabled
    14'b0110000_01_10000, // 3  R4 fall, stb high -> standby
    14'b0000000_01_10000, // 4  R4 fall in standby: none
    14'b1000000_11_10110, // 5  R3 low slope, tx held off, R5 inh float
    14'b1010000_11_11110, // 6  R3 txd high arms tx
    14'b0010000_00_00000, // 7  R4 R6 fall, stb low -> sleep
    14'b1010000_00_00000, // 8  R7 en rise in sleep ignored
    14'b1011000_01_10000, // 9  R7 wake -> standby
    14'b0010000_01_10000, // 10
    14'b0010010_01_10000, // 11 R9
    14'b1010010_01_10000, // 12 R9 rise during reset-active ignored
    14'b1010000_01_10000, // 13 R9 edge not replayed
    14'b0110000_01_10000, // 14
    14'b1110000_10_11011, // 15 R2
    14'b1110100_01_10000, // 16 R8 uv -> standby
    14'b1110000_01_10000, // 17 R8 stays standby
    14'b0110000_01_10000, // 18
    14'b1110000_10_11011, // 19
    14'b1110001_10_00011, // 20 R10 tsd masks vreg and tx
    14'b1110000_10_11011, // 21 R10 recovery
    14'b0110000_01_10000, // 22
    14'b0100000_01_10000, // 23
    14'b1100000_11_10111, // 24 R3 R5 low slope with inh high
    14'b1010000_11_11111, // 25 R5 stb change after entry ignored
    14'b0010000_00_00000, // 26 R4 sleep
    14'b0010100_00_00000, // 27 R8 uv in sleep ignored
    14'b0011000_01_10000  // 28 R7 wake
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 0, stb = 0, txd = 1, wake = 0, uv = 0, rst_act = 0, tsd = 0;
  logic [1:0] mode;
  logic vreg_en, tx_en, slope_low, term_res, inh_hi;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_mode_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .stb_i(stb), .txd_i(txd),
    .wake_i(wake), .uv_i(uv), .rst_act_i(rst_act), .tsd_i(tsd),
    .mode_o(mode), .vreg_en_o(vreg_en), .tx_en_o(tx_en),
    .slope_low_o(slope_low), .term_res_o(term_res), .inh_hi_o(inh_hi)
  );

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {mode,vreg,tx,slope,term,inh} got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {mode, vreg_en, tx_en, slope_low, term_res, inh_hi};
  endfunction

  initial begin
    #(CLK_PERIOD*3);
    chk("R1 reset held", outs(), 7'b01_10000);
    @(negedge clk) rst_ni = 1'b1;
    repeat (HOLD) @(posedge clk);
    @(negedge clk) chk("R1 after release", outs(), 7'b01_10000);

    for (int i = 0; i < NVEC; i++) begin
      {en, stb, txd, wake, uv, rst_act, tsd} = VEC[i][13:7];
      repeat (HOLD) @(posedge clk);
      @(negedge clk);
      chk($sformatf("vector %0d (R1..R10 per row)", i), outs(), VEC[i][6:0]);
    end

    // R2 exact latency: standby, stb/txd high
    en = 0; stb = 1; txd = 1;
    repeat (HOLD) @(posedge clk);
    @(negedge clk) en = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) chk("R2 not yet after two edges", outs(), 7'b01_10000);
    @(negedge clk) chk("R2 on third edge", outs(), 7'b10_11011);

    // R1 asynchronous reset from normal mode
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #1 chk("R1 async reset", outs(), 7'b01_10000);
    en = 0;
    @(negedge clk) rst_ni = 1'b1;
    repeat (HOLD) @(posedge clk);
    @(negedge clk) chk("R1 standby after re-reset", outs(), 7'b01_10000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule